// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides, for every memory access, whether the access may proceed. Address matching happens upstream: the block receives the index of the region that was hit, the kind of access (data read, data write or instruction fetch), the privilege level of the requester and the access address. Software sets up the checking through a small register port. That port holds a global enable bit, a cacheable bit and a bufferable bit for each region, and a 4-bit permission code for each region. The codes are packed eight to a 32-bit word.

Each accepted access produces one registered result. The result carries the allow/deny decision and the cacheable and bufferable attributes of the region. A denied access also raises a one-cycle violation pulse. A denied instruction fetch raises a second pulse as well, and its address is latched for the exception logic. When the enable bit is clear, every access is allowed and no pulse is raised.

Accesses enter through a valid/ready handshake, and results leave through one. An access is taken on a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the result slot is empty or is being drained in the same cycle. A result stays valid and unchanged until `res_ready` is seen high. The register port and the violation outputs are plain signals with no handshake. The region count must be a multiple of eight and at most 32.

Top module: `region_perm_checker`

## Requirements
- R1: After reset, every register reads as zero: the enable bit, the cacheable bits, the bufferable bits and all permission words. `res_valid`, `viol` and `fetch_viol` are low, and `fault_addr` is zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_sel`, and `cfg_rdata` returns that register combinationally. The selects are: 0 control (enable in bit 0), 1 cacheable bits, 2 bufferable bits, and 3+k permission word k. In permission word k, region 8k+j uses bits [4j+3:4j].
- R3: While the enable bit is 0, every access is allowed and neither `viol` nor `fetch_viol` is raised.
- R4: Codes 0..3 give the privileged level read access. Code bit 1 adds write and code bit 0 adds execute. The unprivileged level gets nothing.
- R5: Codes 4..7 give both levels read access. Code bit 1 adds write and code bit 0 adds execute.
- R6: Code 8 gives the privileged level read/write and the unprivileged level read only. Code 9 gives the privileged level read/write and the unprivileged level read/execute.
- R7: Codes 10 through 15 deny every access at both levels.
- R8: `acc_kind` 0 is a read, 1 is a write and 2 is a fetch that needs execute permission. Kind 3 is always denied while checking is enabled.
- R9: `res_cacheable` and `res_bufferable` carry the region's bits whatever the enable bit or the decision.
- R10: `viol` is high for exactly one cycle after each accepted access that is denied. `fetch_viol` is also high in that cycle only when the denied access is a fetch, and `fault_addr` then takes that access address. `fault_addr` holds its value until the next such event.
- R11: `acc_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the result outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be taken |
| acc_region | input | 4 | Matched region index |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | 1 = privileged requester |
| acc_addr | input | 32 | Access address |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_allow | output | 1 | Access allowed |
| res_cacheable | output | 1 | Region cacheable attribute |
| res_bufferable | output | 1 | Region bufferable attribute |
| viol | output | 1 | One-cycle protection violation pulse |
| fetch_viol | output | 1 | One-cycle instruction-side violation pulse |
| fault_addr | output | 32 | Address of the last denied fetch |

## Verification
The bench targets the code boundaries 3/4, 7/8, 9/10 and 15. It also tests the unprivileged level against codes 0..3 and exercises kind 3. A decoder with an off-by-one range would grant user access, or deny it, on exactly one of these codes. The bench stalls the result port while a second access waits, to show that the first result is held and the second is not lost. It also checks that a denied read never moves `fault_addr`, and that the disabled state lets a user write through a no-access region with no pulse. Random traffic mixes configuration writes with accesses, which exposes a wrong nibble position inside the packed permission words.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  typedef struct packed {
    rights_t priv;
    rights_t user;
  } perm_t;

  localparam int SEL_CTRL  = 0;
  localparam int SEL_CACHE = 1;
  localparam int SEL_BUF   = 2;
  localparam int SEL_PERM0 = 3;

  // Expand a 4-bit permission code into rights for both levels.
  function automatic perm_t decode_code(input logic [3:0] code);
    perm_t p;
    p = '0;
    if (code < 4'd4) begin
      p.priv = '{rd: 1'b1, wr: code[1], ex: code[0]};
    end else if (code < 4'd8) begin
      p.priv = '{rd: 1'b1, wr: code[1], ex: code[0]};
      p.user = p.priv;
    end else if (code == 4'd8) begin
      p.priv = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      p.user = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
    end else if (code == 4'd9) begin
      p.priv = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      p.user = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
    end
    return p;
  endfunction
endpackage

// File: rtl/rpc_regs.sv
module rpc_regs
  import rpc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 3,
  localparam int PERM_WORDS = NUM_REGIONS / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     en,
  output logic [NUM_REGIONS-1:0]   cache_bits,
  output logic [NUM_REGIONS-1:0]   buf_bits,
  output logic [PERM_WORDS*32-1:0] codes
);
  logic                     en_r;
  logic [NUM_REGIONS-1:0]   cache_r;
  logic [NUM_REGIONS-1:0]   buf_r;
  logic [PERM_WORDS*32-1:0] perm_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r    <= 1'b0;
      cache_r <= '0;
      buf_r   <= '0;
      perm_r  <= '0;
    end else if (we) begin
      if (sel == SEL_W'(SEL_CTRL))  en_r    <= wdata[0];
      if (sel == SEL_W'(SEL_CACHE)) cache_r <= wdata[NUM_REGIONS-1:0];
      if (sel == SEL_W'(SEL_BUF))   buf_r   <= wdata[NUM_REGIONS-1:0];
      for (int w = 0; w < PERM_WORDS; w++) begin
        if (sel == SEL_W'(SEL_PERM0 + w)) perm_r[w*32 +: 32] <= wdata[31:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_W'(SEL_CTRL))  rdata[0] = en_r;
    if (sel == SEL_W'(SEL_CACHE)) rdata[NUM_REGIONS-1:0] = cache_r;
    if (sel == SEL_W'(SEL_BUF))   rdata[NUM_REGIONS-1:0] = buf_r;
    for (int w = 0; w < PERM_WORDS; w++) begin
      if (sel == SEL_W'(SEL_PERM0 + w)) rdata[31:0] = perm_r[w*32 +: 32];
    end
  end

  assign en         = en_r;
  assign cache_bits = cache_r;
  assign buf_bits   = buf_r;
  assign codes      = perm_r;
endmodule

// File: rtl/rpc_rights_check.sv
module rpc_rights_check
  import rpc_pkg::*;
(
  input  logic [3:0] code,
  input  logic [1:0] kind,
  input  logic       priv,
  output logic       allow
);
  perm_t   perm;
  rights_t r;

  always_comb begin
    perm = decode_code(code);
    r    = priv ? perm.priv : perm.user;
    case (acc_kind_e'(kind))
      ACC_READ:  allow = r.rd;
      ACC_WRITE: allow = r.wr;
      ACC_FETCH: allow = r.ex;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/rpc_result_stage.sv
module rpc_result_stage
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              en,
  input  logic              allow_raw,
  input  logic [1:0]        kind,
  input  logic              cache_bit,
  input  logic              buf_bit,
  input  logic [ADDR_W-1:0] addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_allow,
  output logic              res_cacheable,
  output logic              res_bufferable,
  output logic              viol,
  output logic              fetch_viol,
  output logic [ADDR_W-1:0] fault_addr
);
  logic take;
  logic deny;
  logic fetch_deny;

  assign acc_ready  = !res_valid || res_ready;
  assign take       = acc_valid && acc_ready;
  assign deny       = en && !allow_raw;
  assign fetch_deny = deny && (acc_kind_e'(kind) == ACC_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_allow      <= 1'b0;
      res_cacheable  <= 1'b0;
      res_bufferable <= 1'b0;
      viol           <= 1'b0;
      fetch_viol     <= 1'b0;
      fault_addr     <= '0;
    end else begin
      viol       <= take && deny;
      fetch_viol <= take && fetch_deny;
      if (take) begin
        res_valid      <= 1'b1;
        res_allow      <= !deny;
        res_cacheable  <= cache_bit;
        res_bufferable <= buf_bit;
        if (fetch_deny) fault_addr <= addr;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/region_perm_checker.sv
module region_perm_checker
  import rpc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 3,
  localparam int RGN_W      = $clog2(NUM_REGIONS),
  localparam int PERM_WORDS = NUM_REGIONS / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [RGN_W-1:0]  acc_region,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_allow,
  output logic              res_cacheable,
  output logic              res_bufferable,
  output logic              viol,
  output logic              fetch_viol,
  output logic [ADDR_W-1:0] fault_addr
);
  logic                     en_q;
  logic [NUM_REGIONS-1:0]   cache_bits;
  logic [NUM_REGIONS-1:0]   buf_bits;
  logic [PERM_WORDS*32-1:0] codes;
  logic [3:0]               sel_code;
  logic                     allow_raw;

  rpc_regs #(
    .NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en(en_q), .cache_bits(cache_bits), .buf_bits(buf_bits),
    .codes(codes)
  );

  assign sel_code = codes[{acc_region, 2'b00} +: 4];

  rpc_rights_check u_rights (
    .code(sel_code), .kind(acc_kind), .priv(acc_priv), .allow(allow_raw)
  );

  rpc_result_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .en(en_q), .allow_raw(allow_raw), .kind(acc_kind),
    .cache_bit(cache_bits[acc_region]), .buf_bit(buf_bits[acc_region]),
    .addr(acc_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_allow(res_allow), .res_cacheable(res_cacheable),
    .res_bufferable(res_bufferable), .viol(viol), .fetch_viol(fetch_viol),
    .fault_addr(fault_addr)
  );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_allow,
  input logic              res_cacheable,
  input logic              res_bufferable,
  input logic              viol,
  input logic              fetch_viol,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              en_q
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_allow)
      && $stable(res_cacheable) && $stable(res_bufferable));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !acc_ready);

  a_r10_from_take: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(acc_valid && acc_ready));

  a_r10_denied: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> res_valid && !res_allow);

  a_r10_fetch_subset: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_viol |-> viol);

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> fetch_viol);

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && acc_ready && !en_q) |-> !viol && res_allow);
endmodule

bind region_perm_checker rpc_checker #(.ADDR_W(ADDR_W)) u_rpc_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_allow(res_allow),
  .res_cacheable(res_cacheable), .res_bufferable(res_bufferable),
  .viol(viol), .fetch_viol(fetch_viol), .fault_addr(fault_addr), .en_q(en_q)
);

// File: tb/region_perm_checker_tb_top.sv
module region_perm_checker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [3:0]  acc_region = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_priv = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_allow, res_cacheable, res_bufferable, viol, fetch_viol;
  logic [31:0] fault_addr;

  int n_checks = 0;
  int n_errors = 0;

  logic        m_en = 1'b0;
  logic [15:0] m_c = '0, m_b = '0;
  logic [63:0] m_perm = '0;
  logic [31:0] m_fault = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_perm_checker dut_i (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_allow(input logic [3:0] c, input logic [1:0] k, input bit p);
    bit r, w, x;
    r = 0; w = 0; x = 0;
    if (c <= 4'd3) begin
      if (p) begin r = 1; w = c[1]; x = c[0]; end
    end else if (c <= 4'd7) begin
      r = 1; w = c[1]; x = c[0];
    end else if (c == 4'd8) begin
      r = 1; w = p;
    end else if (c == 4'd9) begin
      r = 1; w = p; x = !p;
    end
    case (k)
      2'd0: return r;
      2'd1: return w;
      2'd2: return x;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] c, input logic [1:0] k, input bit en);
    if (!en) return "R3";
    if (k == 2'd3) return "R8";
    if (c <= 4'd3) return "R4";
    if (c <= 4'd7) return "R5";
    if (c <= 4'd9) return "R6";
    return "R7";
  endfunction

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_en = data[0];
      3'd1: m_c = data[15:0];
      3'd2: m_b = data[15:0];
      3'd3: m_perm[31:0] = data;
      3'd4: m_perm[63:32] = data;
      default: ;
    endcase
  endtask

  task automatic set_code(input int rg, input logic [3:0] c);
    logic [63:0] p;
    p = m_perm;
    p[rg*4 +: 4] = c;
    if (rg < 8) wr_reg(3'd3, p[31:0]);
    else        wr_reg(3'd4, p[63:32]);
  endtask

  // Issue one access with res_ready high and check the registered result.
  task automatic access(input logic [3:0] rg, input logic [1:0] k,
                        input bit p, input logic [31:0] addr);
    logic [3:0] c;
    bit al, dn;
    string t;
    c  = m_perm[rg*4 +: 4];
    al = !m_en || exp_allow(c, k, p);
    dn = !al;
    t  = tag_for(c, k, m_en);
    @(negedge clk);
    acc_valid = 1'b1; acc_region = rg; acc_kind = k; acc_priv = p; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    if (dn && k == 2'd2) m_fault = addr;
    check("R11", "res_valid", {31'd0, res_valid}, 32'd1);
    check(t, "res_allow", {31'd0, res_allow}, {31'd0, al});
    check("R9", "res_cacheable", {31'd0, res_cacheable}, {31'd0, m_c[rg]});
    check("R9", "res_bufferable", {31'd0, res_bufferable}, {31'd0, m_b[rg]});
    check("R10", "viol", {31'd0, viol}, {31'd0, dn});
    check("R10", "fetch_viol", {31'd0, fetch_viol}, {31'd0, dn && k == 2'd2});
    check("R10", "fault_addr", fault_addr, m_fault);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 5; s++) begin
      cfg_sel = 3'(s); #1;
      check("R1", "reg reset", cfg_rdata, 32'd0);
    end
    check("R1", "res_valid", {31'd0, res_valid}, 32'd0);
    check("R1", "viol", {30'd0, viol, fetch_viol}, 32'd0);
    check("R1", "fault_addr", fault_addr, 32'd0);

    // R2: write/readback and nibble placement
    wr_reg(3'd1, 32'h0000_A5C3);
    wr_reg(3'd2, 32'h0000_3C5A);
    wr_reg(3'd3, 32'h7654_3210);
    wr_reg(3'd4, 32'hFEDC_BA98);
    cfg_sel = 3'd1; #1; check("R2", "cache rd", cfg_rdata, 32'h0000_A5C3);
    cfg_sel = 3'd2; #1; check("R2", "buf rd", cfg_rdata, 32'h0000_3C5A);
    cfg_sel = 3'd3; #1; check("R2", "permA rd", cfg_rdata, 32'h7654_3210);
    cfg_sel = 3'd4; #1; check("R2", "permB rd", cfg_rdata, 32'hFEDC_BA98);

    // R3 and R9: disabled, user write to a no-access region (region 10 code 10)
    access(4'd10, 2'd1, 1'b0, 32'h1000_0000);
    access(4'd15, 2'd2, 1'b0, 32'h1000_0004);
    wr_reg(3'd0, 32'd1);
    cfg_sel = 3'd0; #1; check("R2", "ctrl rd", cfg_rdata, 32'd1);

    // Directed codes at boundaries, every kind, both levels
    for (int rg = 0; rg < 16; rg++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 2; p++)
          access(4'(rg), 2'(k), p[0], 32'h2000_0000 + 32'(rg * 16 + k * 2 + p));

    // R10: denied read leaves fault_addr; pulse ends the cycle after
    set_code(3, 4'd10);
    access(4'd3, 2'd0, 1'b1, 32'hDEAD_0000);
    @(negedge clk);
    check("R10", "viol pulse end", {30'd0, viol, fetch_viol}, 32'd0);
    access(4'd3, 2'd2, 1'b1, 32'hCAFE_0010);
    @(negedge clk);
    check("R10", "fault_addr hold", fault_addr, 32'hCAFE_0010);

    // R11: back-pressure with a second access waiting
    set_code(5, 4'd10);
    @(negedge clk);
    res_ready = 1'b0;
    acc_valid = 1'b1; acc_region = 4'd5; acc_kind = 2'd0; acc_priv = 1'b1; acc_addr = 32'h11;
    @(negedge clk);
    check("R11", "stall res_valid", {31'd0, res_valid}, 32'd1);
    check("R11", "stall acc_ready", {31'd0, acc_ready}, 32'd0);
    acc_region = 4'd4; acc_kind = 2'd0; acc_priv = 1'b0; acc_addr = 32'h22;
    @(negedge clk);
    check("R11", "held allow", {31'd0, res_allow}, 32'd0);
    check("R10", "no repeat pulse", {31'd0, viol}, 32'd0);
    res_ready = 1'b1; #1;
    check("R11", "ready when drained", {31'd0, acc_ready}, 32'd1);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R11", "second result", {31'd0, res_allow}, {31'd0, exp_allow(m_perm[19:16], 2'd0, 1'b0)});
    @(negedge clk);
    check("R11", "slot empties", {31'd0, res_valid}, 32'd0);

    // Random traffic mixed with configuration writes
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) wr_reg(3'($urandom % 5), $urandom);
      access(4'($urandom), 2'($urandom), 1'($urandom), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule